// File: doc/BRIEF.md
# Multi-Context Configuration Memory Controller

This block drives a small configuration store that holds four complete settings ("contexts") of 32 bits each, and one of them at a time feeds the logic it configures. In every clock cycle it decides what the single read port and the single write port of the store do. Three kinds of work compete for them. A context switch loads a newly chosen setting onto the configuration output. A background programming port reads or writes any context while another one is in use. Storage that decays is refreshed by reading a row and writing the same value back.

All requests pass through a registered decode stage whose row selects and enables are visible on the ports. The store then acts one cycle later and reads before it writes within that cycle. A wrapping refresh pointer picks the row to refresh on cycles that have nothing else to do. The pointer moves on only when a write-back of the row it names is actually issued. A read of that same row done for a switch or a programming read therefore counts as its refresh. A behavioural retention model watches the issued writes and flags any context left untouched for too long.

Top module: `ctxmem_ldec`

## Requirements
- R1: Synchronous active-high reset clears cfg_out, prog_rdata, prog_rd_bad, both memory enables and ret_lost, and starts the refresh pointer at context 0 with context 0 active. The store contents are not cleared.
- R2: Latency. The control outputs (mem_rd_en, mem_rd_row, mem_wr_en, mem_wr_row) reflect the inputs sampled one clock edge earlier. The data outputs cfg_out, prog_rdata and prog_rd_bad show the result one edge after that, so nothing changes on them after the first edge.
- R3: A context switch (ctx_switch=1) reads row ctx_sel, makes it the active context, and loads its 32 bits onto cfg_out.
- R4: A programming write (prog_wr=1) stores all 32 bits of prog_wdata into row prog_ctx, with mem_wr_en=1 and mem_wr_row=prog_ctx.
- R5: A programming read (prog_rd=1 without ctx_switch) copies row prog_ctx to prog_rdata and leaves cfg_out unchanged. prog_rdata changes only after a programming read.
- R6: A switch takes the read port from a programming read in the same cycle. prog_rd_bad is then high for exactly one cycle, prog_rdata keeps its previous value and the switch completes normally. prog_rd_bad is low in every other cycle.
- R7: A programming write may share a cycle with a switch or with a programming read. Both take effect. The read sees the row as it was before that cycle's write.
- R8: Read-port priority is switch, then programming read, then refresh of the pointer row. A cycle with none of the three requests refreshes the pointer row (read and write-back of that row) and advances the pointer 0,1,2,3,0. A cycle carrying only a programming write uses no read and does not advance the pointer.
- R9: A read without a concurrent programming write is written back. When the read row equals the pointer, the pointer advances, whether the read came from a switch, a programming read or a refresh. cfg_out is reloaded only by a switch or by a refresh of the active row. A programming write to the active context therefore reaches cfg_out at that row's next refresh.
- R10: ret_lost[c] becomes 1 and stays 1 until reset if row c gets no write or write-back for more than RET_LIMIT cycles. Under mixed traffic with regular idle cycles no bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_switch | input | 1 | Switch strobe for the active context |
| ctx_sel | input | 2 | Context to switch to |
| prog_rd | input | 1 | Programming read strobe |
| prog_wr | input | 1 | Programming write strobe |
| prog_ctx | input | 2 | Row addressed by the programming port |
| prog_wdata | input | 32 | Programming write data |
| prog_rdata | output | 32 | Programming read data |
| prog_rd_bad | output | 1 | One-cycle flag: a programming read lost to a switch |
| cfg_out | output | 32 | Configuration bits of the active context |
| mem_rd_en | output | 1 | Registered read enable for the store |
| mem_rd_row | output | 2 | Registered read row select |
| mem_wr_en | output | 1 | Registered write enable for the store |
| mem_wr_row | output | 2 | Registered write row select |
| ret_lost | output | 4 | Per-context sticky flag from the retention model |

## Verification
Two functions can share a cycle. A context switch can coincide with a programming write, which uses the separate write port. A context switch can also coincide with a programming read, and the two then compete for the one read port. The directed tests raise both requests on the same edge, including a switch and a write to the same row. They judge the result by what cfg_out, prog_rdata and prog_rd_bad show two edges later, and by whether the row selects and the pointer's next refresh row match the priority rules. A switch row that equals the pointer is checked to count as that row's refresh, while a write-only cycle must leave the pointer where it was.

// File: rtl/ctxmem_pkg.sv
`timescale 1ns/1ps
package ctxmem_pkg;

  // What the read port is used for in a given cycle.
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_SWITCH = 2'd1,
    RD_PROG   = 2'd2,
    RD_RFSH   = 2'd3
  } rd_kind_e;

  // Registered control word produced by the decode stage.
  typedef struct packed {
    logic     rd_en;    // read port active
    rd_kind_e kind;     // purpose of the read
    logic     wr_en;    // write port active
    logic     wr_back;  // write data is the row just read (refresh)
    logic     upd_cfg;  // read result goes to the configuration output
    logic     rd_lost;  // programming read displaced by a switch
  } ctl_t;

endpackage

// File: rtl/ctxmem_decode.sv
`timescale 1ns/1ps
module ctxmem_decode
  import ctxmem_pkg::*;
#(
  parameter int NCTX  = 4,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctx_switch,
  input  logic [RW-1:0]    ctx_sel,
  input  logic             prog_rd,
  input  logic             prog_wr,
  input  logic [RW-1:0]    prog_ctx,
  input  logic [WIDTH-1:0] prog_wdata,
  output ctl_t             ctl_q,
  output logic [RW-1:0]    rd_row_q,
  output logic [RW-1:0]    wr_row_q,
  output logic [WIDTH-1:0] wdata_q
);

  logic [RW-1:0] ptr_q;     // refresh pointer
  logic [RW-1:0] active_q;  // operating context

  rd_kind_e      kind_d;
  logic [RW-1:0] rd_row_d;
  logic [RW-1:0] wr_row_d;
  logic          rd_en_d;
  logic          wr_back_d;
  logic          ptr_hit;
  logic [RW-1:0] ptr_next;

  // Read-port arbitration: switch, then programming read, then refresh.
  always_comb begin
    if (ctx_switch) begin
      kind_d   = RD_SWITCH;
      rd_row_d = ctx_sel;
    end else if (prog_rd) begin
      kind_d   = RD_PROG;
      rd_row_d = prog_ctx;
    end else if (!prog_wr) begin
      kind_d   = RD_RFSH;
      rd_row_d = ptr_q;
    end else begin
      kind_d   = RD_NONE;
      rd_row_d = ptr_q;
    end
  end

  assign rd_en_d   = (kind_d != RD_NONE);
  assign wr_back_d = rd_en_d && !prog_wr;
  assign wr_row_d  = prog_wr ? prog_ctx : rd_row_d;

  // Refresh-address comparator: a write-back of the pointer row completes its refresh.
  assign ptr_hit  = wr_back_d && (rd_row_d == ptr_q);
  assign ptr_next = (ptr_q == RW'(NCTX - 1)) ? '0 : ptr_q + RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      rd_row_q <= '0;
      wr_row_q <= '0;
      ptr_q    <= '0;
      active_q <= '0;
    end else begin
      ctl_q.rd_en   <= rd_en_d;
      ctl_q.kind    <= kind_d;
      ctl_q.wr_en   <= prog_wr || rd_en_d;
      ctl_q.wr_back <= wr_back_d;
      ctl_q.upd_cfg <= (kind_d == RD_SWITCH) ||
                       ((kind_d == RD_RFSH) && (ptr_q == active_q));
      ctl_q.rd_lost <= ctx_switch && prog_rd;
      rd_row_q      <= rd_row_d;
      wr_row_q      <= wr_row_d;
      if (ptr_hit)    ptr_q    <= ptr_next;
      if (ctx_switch) active_q <= ctx_sel;
    end
  end

  // Data path register: no reset needed.
  always_ff @(posedge clk) begin
    wdata_q <= prog_wdata;
  end

endmodule

// File: rtl/ctxmem_array.sv
`timescale 1ns/1ps
module ctxmem_array #(
  parameter int NCTX  = 4,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [RW-1:0]    rd_row,
  input  logic             wr_en,
  input  logic             wr_back,
  input  logic [RW-1:0]    wr_row,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [NCTX];

  // Asynchronous read: the value seen is the row before this cycle's write.
  assign rd_data = rd_en ? mem[rd_row] : '0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_back ? mem[rd_row] : wr_data;
  end

endmodule

// File: rtl/ctxmem_retention.sv
`timescale 1ns/1ps
module ctxmem_retention #(
  parameter int NCTX      = 4,
  parameter int RET_LIMIT = 64,
  localparam int RW       = $clog2(NCTX),
  localparam int AW       = $clog2(RET_LIMIT + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  output logic [NCTX-1:0] lost
);

  localparam logic [AW-1:0] LIM = AW'(RET_LIMIT);

  for (genvar c = 0; c < NCTX; c++) begin : g_row
    logic [AW-1:0] age_q;
    logic          lost_q;
    logic          hit;

    assign hit = wr_en && (wr_row == RW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q  <= '0;
        lost_q <= 1'b0;
      end else begin
        if (hit)              age_q <= '0;
        else if (age_q <= LIM) age_q <= age_q + AW'(1);
        if (!hit && age_q == LIM) lost_q <= 1'b1;
      end
    end

    assign lost[c] = lost_q;
  end

endmodule

// File: rtl/ctxmem_ldec.sv
`timescale 1ns/1ps
module ctxmem_ldec
  import ctxmem_pkg::*;
#(
  parameter int NCTX      = 4,
  parameter int WIDTH     = 32,
  parameter int RET_LIMIT = 64,
  localparam int RW       = $clog2(NCTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctx_switch,
  input  logic [RW-1:0]    ctx_sel,
  input  logic             prog_rd,
  input  logic             prog_wr,
  input  logic [RW-1:0]    prog_ctx,
  input  logic [WIDTH-1:0] prog_wdata,
  output logic [WIDTH-1:0] prog_rdata,
  output logic             prog_rd_bad,
  output logic [WIDTH-1:0] cfg_out,
  output logic             mem_rd_en,
  output logic [RW-1:0]    mem_rd_row,
  output logic             mem_wr_en,
  output logic [RW-1:0]    mem_wr_row,
  output logic [NCTX-1:0]  ret_lost
);

  ctl_t             dec_ctl;
  logic [WIDTH-1:0] dec_wdata;
  logic [WIDTH-1:0] rd_data;

  ctxmem_decode #(.NCTX(NCTX), .WIDTH(WIDTH)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .ctx_switch (ctx_switch),
    .ctx_sel    (ctx_sel),
    .prog_rd    (prog_rd),
    .prog_wr    (prog_wr),
    .prog_ctx   (prog_ctx),
    .prog_wdata (prog_wdata),
    .ctl_q      (dec_ctl),
    .rd_row_q   (mem_rd_row),
    .wr_row_q   (mem_wr_row),
    .wdata_q    (dec_wdata)
  );

  assign mem_rd_en = dec_ctl.rd_en;
  assign mem_wr_en = dec_ctl.wr_en;

  ctxmem_array #(.NCTX(NCTX), .WIDTH(WIDTH)) u_array (
    .clk     (clk),
    .rd_en   (dec_ctl.rd_en),
    .rd_row  (mem_rd_row),
    .wr_en   (dec_ctl.wr_en),
    .wr_back (dec_ctl.wr_back),
    .wr_row  (mem_wr_row),
    .wr_data (dec_wdata),
    .rd_data (rd_data)
  );

  ctxmem_retention #(.NCTX(NCTX), .RET_LIMIT(RET_LIMIT)) u_retention (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (dec_ctl.wr_en),
    .wr_row (mem_wr_row),
    .lost   (ret_lost)
  );

  // Output stage: captures the read result in the same cycle the store acts.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_out     <= '0;
      prog_rdata  <= '0;
      prog_rd_bad <= 1'b0;
    end else begin
      prog_rd_bad <= dec_ctl.rd_lost;
      if (dec_ctl.upd_cfg)          cfg_out    <= rd_data;
      if (dec_ctl.kind == RD_PROG)  prog_rdata <= rd_data;
    end
  end

endmodule

// File: rtl/ctxmem_ldec_chk.sv
`timescale 1ns/1ps
module ctxmem_ldec_chk
  import ctxmem_pkg::*;
#(
  parameter int NCTX  = 4,
  parameter int WIDTH = 32,
  localparam int RW   = $clog2(NCTX)
) (
  input logic             clk,
  input logic             rst,
  input logic             ctx_switch,
  input logic [RW-1:0]    ctx_sel,
  input logic             prog_rd,
  input logic             prog_wr,
  input logic [RW-1:0]    prog_ctx,
  input ctl_t             ctl,
  input logic             mem_rd_en,
  input logic [RW-1:0]    mem_rd_row,
  input logic             mem_wr_en,
  input logic [RW-1:0]    mem_wr_row,
  input logic             prog_rd_bad,
  input logic [WIDTH-1:0] cfg_out,
  input logic [WIDTH-1:0] prog_rdata
);

  // Edges seen since reset, saturating; guards every look into the past.
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)                 seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  p_switch_row_r3: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0 && $past(ctx_switch)) |-> (mem_rd_en && mem_rd_row == $past(ctx_sel)));

  p_prog_wr_row_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0 && $past(prog_wr)) |-> (mem_wr_en && !ctl.wr_back && mem_wr_row == $past(prog_ctx)));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0 && $past(ctl.kind) != RD_PROG) |-> $stable(prog_rdata));

  p_lost_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q >= 2'd2) |-> (prog_rd_bad == $past(ctx_switch && prog_rd, 2)));

  p_refresh_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0 && ctl.kind == RD_RFSH) |-> $past(!ctx_switch && !prog_rd && !prog_wr));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_q != 2'd0 && !$past(ctl.upd_cfg)) |-> $stable(cfg_out));

endmodule

bind ctxmem_ldec ctxmem_ldec_chk #(.NCTX(NCTX), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctx_switch  (ctx_switch),
  .ctx_sel     (ctx_sel),
  .prog_rd     (prog_rd),
  .prog_wr     (prog_wr),
  .prog_ctx    (prog_ctx),
  .ctl         (dec_ctl),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_row  (mem_rd_row),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_row  (mem_wr_row),
  .prog_rd_bad (prog_rd_bad),
  .cfg_out     (cfg_out),
  .prog_rdata  (prog_rdata)
);

// File: tb/ctxmem_ldec_bench.sv
`timescale 1ns/1ps
module ctxmem_ldec_bench;

  localparam int NCTX = 4;
  localparam int RET  = 64;
  localparam int NVEC = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctx_switch, prog_rd, prog_wr;
  logic [1:0]  ctx_sel, prog_ctx;
  logic [31:0] prog_wdata;
  logic [31:0] prog_rdata, cfg_out;
  logic        prog_rd_bad, mem_rd_en, mem_wr_en;
  logic [1:0]  mem_rd_row, mem_wr_row;
  logic [3:0]  ret_lost;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctxmem_ldec #(.NCTX(NCTX), .WIDTH(32), .RET_LIMIT(RET)) u_ctxmem_ldec (
    .clk(clk), .rst(rst), .ctx_switch(ctx_switch), .ctx_sel(ctx_sel),
    .prog_rd(prog_rd), .prog_wr(prog_wr), .prog_ctx(prog_ctx),
    .prog_wdata(prog_wdata), .prog_rdata(prog_rdata), .prog_rd_bad(prog_rd_bad),
    .cfg_out(cfg_out), .mem_rd_en(mem_rd_en), .mem_rd_row(mem_rd_row),
    .mem_wr_en(mem_wr_en), .mem_wr_row(mem_wr_row), .ret_lost(ret_lost)
  );

  // Vector: sw | sel[2] | prd | pwr | pctx[2] || exp rd_en | rd_row[2] | wr_en | wr_row[2]
  // Starts right after reset: pointer 0, active context 0.
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_00_0_1_00_0_00_1_00,  // write-only rows: no read, pointer holds (R8)
    13'b0_00_0_1_01_0_00_1_01,
    13'b0_00_0_1_10_0_00_1_10,
    13'b0_00_0_1_11_0_00_1_11,
    13'b0_00_0_0_00_1_00_1_00,  // idle: refresh row 0 -> pointer 1
    13'b0_00_0_0_00_1_01_1_01,  // idle: refresh row 1 -> pointer 2
    13'b1_10_0_0_00_1_10_1_10,  // switch to 2 matches pointer -> 3 (R9)
    13'b0_00_1_0_01_1_01_1_01,  // programming read row 1, written back
    13'b1_01_0_1_11_1_01_1_11,  // switch + write share the cycle (R7)
    13'b0_00_0_1_00_0_00_1_00,  // write only
    13'b0_00_0_0_00_1_11_1_11,  // pointer still 3 -> refresh row 3 -> 0
    13'b0_00_0_0_00_1_00_1_00,  // -> 1
    13'b0_00_0_0_00_1_01_1_01,  // -> 2
    13'b1_00_1_0_10_1_00_1_00,  // switch beats read (R6), row 0 != pointer
    13'b0_00_0_0_00_1_10_1_10   // pointer was not moved by the previous row
  };

  function automatic logic [31:0] pat(int c, int s);
    return 32'h5A000000 + 32'(c) * 32'h00110000 + 32'(s) * 32'h00000101;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit sw, logic [1:0] sel, bit prd, bit pwr, logic [1:0] pc, logic [31:0] wd);
    ctx_switch = sw; ctx_sel = sel; prog_rd = prd; prog_wr = pwr;
    prog_ctx = pc; prog_wdata = wd;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    logic [15:0] lfsr;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cfg_out, prog_rdata} === 64'd0, "R1 data outputs at reset", cfg_out | prog_rdata, 32'd0);
    chk({prog_rd_bad, mem_rd_en, mem_wr_en, ret_lost} === 7'd0, "R1 flags at reset",
        {25'd0, prog_rd_bad, mem_rd_en, mem_wr_en, ret_lost}, 32'd0);
    rst = 1'b0;

    // Table walk: control outputs one edge after each vector (R2, R8)
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][12], VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7:6], pat(VEC[i][7:6], i));
      @(negedge clk);
      chk({mem_rd_en, mem_rd_en ? mem_rd_row : 2'b00, mem_wr_en, mem_wr_row} === VEC[i][5:0],
          $sformatf("R8 control vector %0d", i),
          {26'd0, mem_rd_en, mem_rd_en ? mem_rd_row : 2'b00, mem_wr_en, mem_wr_row},
          {26'd0, VEC[i][5:0]});
    end
    idle();
    repeat (2) @(negedge clk);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R4: program all rows
    for (int c = 0; c < NCTX; c++) begin
      drive(1'b0, 2'd0, 1'b0, 1'b1, 2'(c), pat(c, 7));
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);

    // R2 / R3: switch to context 2
    prev = cfg_out;
    drive(1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'd0);
    @(negedge clk); idle();
    chk(cfg_out === prev, "R2 cfg_out unchanged after one edge", cfg_out, prev);
    @(negedge clk);
    chk(cfg_out === pat(2, 7), "R3 cfg_out after switch", cfg_out, pat(2, 7));

    // R5: programming read of row 3
    drive(1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 32'd0);
    @(negedge clk); idle(); @(negedge clk);
    chk(prog_rdata === pat(3, 7), "R5 prog_rdata", prog_rdata, pat(3, 7));
    chk(cfg_out === pat(2, 7), "R5 cfg_out untouched by read", cfg_out, pat(2, 7));

    // R6: switch to 1 with a programming read of row 0
    drive(1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 32'd0);
    @(negedge clk); idle(); @(negedge clk);
    chk(prog_rd_bad === 1'b1, "R6 invalid-read flag raised", {31'd0, prog_rd_bad}, 32'd1);
    chk(prog_rdata === pat(3, 7), "R6 prog_rdata held", prog_rdata, pat(3, 7));
    chk(cfg_out === pat(1, 7), "R6 switch still completes", cfg_out, pat(1, 7));
    @(negedge clk);
    chk(prog_rd_bad === 1'b0, "R6 flag lasts one cycle", {31'd0, prog_rd_bad}, 32'd0);

    // R7: switch to 0 with a write to row 0 in the same cycle
    drive(1'b1, 2'd0, 1'b0, 1'b1, 2'd0, pat(0, 9));
    @(negedge clk); idle(); @(negedge clk);
    chk(cfg_out === pat(0, 7), "R7 switch reads row before write", cfg_out, pat(0, 7));
    drive(1'b0, 2'd0, 1'b1, 1'b1, 2'd0, pat(0, 11));
    @(negedge clk); idle(); @(negedge clk);
    chk(prog_rdata === pat(0, 9), "R7 read before concurrent write", prog_rdata, pat(0, 9));
    drive(1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 32'd0);
    @(negedge clk); idle(); @(negedge clk);
    chk(prog_rdata === pat(0, 11), "R4 concurrent write stored", prog_rdata, pat(0, 11));

    // R9: write to active row 0 reaches cfg_out only through its refresh
    drive(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, pat(0, 13));
    @(negedge clk); idle(); @(negedge clk);
    chk(cfg_out !== pat(0, 13), "R9 write does not load cfg_out directly", cfg_out, pat(0, 13));
    repeat (8) @(negedge clk);
    chk(cfg_out === pat(0, 13), "R9 refresh of active row reloads cfg_out", cfg_out, pat(0, 13));

    // R10: mixed traffic with idle cycles loses nothing
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] < 3'd3) idle();
      else case (lfsr[4:3])
        2'd0: drive(1'b1, lfsr[6:5], 1'b0, 1'b0, 2'd0, 32'd0);
        2'd1: drive(1'b0, 2'd0, 1'b1, 1'b0, lfsr[6:5], 32'd0);
        2'd2: drive(1'b0, 2'd0, 1'b0, 1'b1, lfsr[6:5], {lfsr, ~lfsr});
        default: drive(1'b1, lfsr[8:7], 1'b0, 1'b1, lfsr[6:5], {~lfsr, lfsr});
      endcase
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    chk(ret_lost === 4'b0000, "R10 no context lost under mixed traffic", {28'd0, ret_lost}, 32'd0);

    // R10: writes only to row 0 starve the others
    drive(1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 32'h0F0F0F0F);
    repeat (RET + 8) @(negedge clk);
    idle();
    @(negedge clk);
    chk(ret_lost === 4'b1110, "R10 starved rows flagged", {28'd0, ret_lost}, 32'hE);

    // R1: reset clears the sticky flags
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ret_lost === 4'b0000, "R1 ret_lost cleared by reset", {28'd0, ret_lost}, 32'd0);
    chk(cfg_out === 32'd0, "R1 cfg_out cleared by reset", cfg_out, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule